// File: doc/BRIEF.md
# Cacheability Range and Exclusion Decoder

This block decides, for every physical address on a 26-bit memory bus, whether the access may be held in the secondary cache. It gathers the relevant configuration fields into one registered flag: a global cache switch, an upper limit counted in 4 MB steps, an optional exclusion of the 32 KB video BIOS window, and a set of programmable non-cacheable blocks. Each block has a power-of-two size and is aligned to that size.

The installed memory size, given in megabytes, is also an input. When only 1 MB or 2 MB is fitted, the installed size sets the cacheable range and the limit field is ignored. All decoding is combinational. The result is captured in one flop, so `cacheable` always reflects the inputs presented one clock earlier.

Top module: `cache_range_dec`

## Requirements
- R1: When `cache_en` is 0, `cacheable` is 0 for every address.
- R2: For a `limit_code` n from 1 to 15 and installed memory other than 1 or 2 MB, an address is within the limit only when it is below n × 4 MB. Address n × 4 MB itself is not cacheable.
- R3: A `limit_code` of 0 places the whole 64 MB address space within the limit.
- R4: When `mem_mb` is 1 or 2, the limit is exactly `mem_mb` megabytes, whatever `limit_code` holds. Any other `mem_mb` value leaves the limit to `limit_code`.
- R5: When `video_nc` is 1, addresses C0000h through C7FFFh inclusive are not cacheable. C8000h and BFFFFh are unaffected.
- R6: When `video_nc` is 0, the video window is cacheable like any other address.
- R7: Block size codes 0, 1, 2 and 3 give blocks of 64 KB, 128 KB, 256 KB and 512 KB. An address inside an enabled block is not cacheable.
- R8: A block size code with bit 2 set (4 to 7) disables that block.
- R9: A block's 10-bit base gives address bits 25..16, so base bits 9..8 are address bits 25..24. Base bits that fall inside the block size are ignored, which aligns the block to its size.
- R10: Each block has its own fields. Block g uses `blk_size[3g+2:3g]` and `blk_base[10g+9:10g]`, and the blocks exclude addresses independently of each other.
- R11: `cacheable` is 0 while `rst_n` is low. Otherwise it changes only at a rising clock edge, to the decode of the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 26 | Physical address to classify |
| cache_en | input | 1 | Global cache enable |
| limit_code | input | 4 | Upper limit in 4 MB steps; 0 means 64 MB |
| mem_mb | input | 7 | Installed memory in MB |
| video_nc | input | 1 | Exclude the video BIOS window from caching |
| blk_size | input | 6 | Size codes of the two non-cacheable blocks |
| blk_base | input | 20 | Base bits 25..16 of the two non-cacheable blocks |
| cacheable | output | 1 | Registered cacheability decision |

## Verification
Addresses are placed on both sides of every edge: one address below each limit and the address at the limit, the first and last bytes of the video window and their neighbours, and each block's first byte, last byte and the bytes just outside it. These pairs show whether a comparison is off by one and whether it is strict or inclusive. The same addresses are then decoded under changed settings: a limit code of 0, small installed memory, reserved size codes, and base values with low bits set. Those runs separate the special encodings from the plain arithmetic. Programming one block at a time, and then both at once, shows that the two blocks do not affect each other.

// File: rtl/cache_dec_pkg.sv
package cache_dec_pkg;
  localparam int ADDR_W   = 26;   // physical address width
  localparam int LIM_W    = 4;    // limit code width (4 MB steps over 64 MB)
  localparam int MEMSZ_W  = 7;    // installed memory size in MB
  localparam int BLK_LSB  = 16;   // block base granularity (64 KB)
  localparam int SZ_W     = 3;    // block size code width
  localparam int MB_LSB   = 20;   // 1 MB granularity
  localparam int VID_LSB  = 15;   // 32 KB video window
  localparam logic [ADDR_W-1:0] VID_BASE = 26'h00C0000;
endpackage

// File: rtl/ncb_match.sv
module ncb_match
  import cache_dec_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int LSB    = BLK_LSB,
  parameter int SW     = SZ_W,
  localparam int BW    = AW - LSB
) (
  input  logic [AW-1:0] addr,
  input  logic [SW-1:0] size_code,
  input  logic [BW-1:0] base,
  output logic          hit
);
  // Upper code bit disables the block; lower bits scale the size.
  logic [BW-1:0] keep;
  logic          enabled;

  always_comb begin
    enabled = ~size_code[SW-1];
    keep    = {BW{1'b1}} << size_code[SW-2:0];
    hit     = enabled && (((addr[AW-1:LSB] ^ base) & keep) == '0);
  end
endmodule

// File: rtl/limit_cmp.sv
module limit_cmp
  import cache_dec_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int LW  = LIM_W,
  parameter int MW  = MEMSZ_W,
  parameter int MBL = MB_LSB,
  localparam int MBI_W = AW - MBL
) (
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] limit_code,
  input  logic [MW-1:0] mem_mb,
  output logic          below
);
  logic [LW-1:0]    seg;
  logic [MBI_W-1:0] mb_idx;
  logic [MW-1:0]    mb_ext;
  logic             small_mem;
  logic             below_code;
  logic             below_mem;

  always_comb begin
    seg        = addr[AW-1 -: LW];
    mb_idx     = addr[AW-1:MBL];
    mb_ext     = MW'(mb_idx);
    small_mem  = (mem_mb == MW'(1)) || (mem_mb == MW'(2));
    below_code = (limit_code == '0) || (seg < limit_code);
    below_mem  = mb_ext < mem_mb;
    below      = small_mem ? below_mem : below_code;
  end
endmodule

// File: rtl/video_win.sv
module video_win
  import cache_dec_pkg::*;
#(
  parameter int                AW   = ADDR_W,
  parameter int                WLSB = VID_LSB,
  parameter logic [AW-1:0]     WBASE = VID_BASE
) (
  input  logic [AW-1:0] addr,
  input  logic          excl_en,
  output logic          excluded
);
  always_comb excluded = excl_en && (addr[AW-1:WLSB] == WBASE[AW-1:WLSB]);
endmodule

// File: rtl/cache_range_dec.sv
module cache_range_dec
  import cache_dec_pkg::*;
#(
  parameter int NUM_BLK = 2,
  localparam int BW     = ADDR_W - BLK_LSB
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cache_en,
  input  logic [LIM_W-1:0]        limit_code,
  input  logic [MEMSZ_W-1:0]      mem_mb,
  input  logic                    video_nc,
  input  logic [NUM_BLK*SZ_W-1:0] blk_size,
  input  logic [NUM_BLK*BW-1:0]   blk_base,
  output logic                    cacheable
);
  logic               below;
  logic               vid_excl;
  logic [NUM_BLK-1:0] blk_hit;
  logic               cacheable_nxt;

  limit_cmp u_limit (
    .addr       (addr),
    .limit_code (limit_code),
    .mem_mb     (mem_mb),
    .below      (below)
  );

  video_win u_video (
    .addr     (addr),
    .excl_en  (video_nc),
    .excluded (vid_excl)
  );

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    ncb_match u_match (
      .addr      (addr),
      .size_code (blk_size[g*SZ_W +: SZ_W]),
      .base      (blk_base[g*BW +: BW]),
      .hit       (blk_hit[g])
    );
  end

  always_comb begin
    cacheable_nxt = cache_en && below && !vid_excl && !(|blk_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cacheable <= 1'b0;
    else        cacheable <= cacheable_nxt;
  end
endmodule

// File: rtl/cache_range_dec_chk.sv
module cache_range_dec_chk
  import cache_dec_pkg::*;
#(
  parameter int NUM_BLK = 2,
  localparam int BW     = ADDR_W - BLK_LSB
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cache_en,
  input  logic [LIM_W-1:0]        limit_code,
  input  logic [MEMSZ_W-1:0]      mem_mb,
  input  logic                    video_nc,
  input  logic [NUM_BLK*SZ_W-1:0] blk_size,
  input  logic [NUM_BLK*BW-1:0]   blk_base,
  input  logic                    cacheable
);
  // Inputs seen at the previous edge, which the output now reflects.
  logic                    q_vld;
  logic [ADDR_W-1:0]       q_addr;
  logic                    q_en;
  logic [LIM_W-1:0]        q_lim;
  logic [MEMSZ_W-1:0]      q_mem;
  logic                    q_vnc;
  logic [NUM_BLK*SZ_W-1:0] q_sz;
  logic [NUM_BLK*BW-1:0]   q_base;
  logic                    q_small;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld  <= 1'b0;
      q_addr <= '0;
      q_en   <= 1'b0;
      q_lim  <= '0;
      q_mem  <= '0;
      q_vnc  <= 1'b0;
      q_sz   <= '0;
      q_base <= '0;
    end else begin
      q_vld  <= 1'b1;
      q_addr <= addr;
      q_en   <= cache_en;
      q_lim  <= limit_code;
      q_mem  <= mem_mb;
      q_vnc  <= video_nc;
      q_sz   <= blk_size;
      q_base <= blk_base;
    end
  end

  always_comb q_small = (q_mem == MEMSZ_W'(1)) || (q_mem == MEMSZ_W'(2));

  p_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld && !q_en |-> !cacheable);

  p_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld && !q_small && (q_lim != '0) && (q_addr[ADDR_W-1 -: LIM_W] >= q_lim) |-> !cacheable);

  p_small_r4: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld && q_small && (q_addr >= (ADDR_W'(q_mem) << MB_LSB)) |-> !cacheable);

  p_video_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld && q_vnc && (q_addr >= VID_BASE) && (q_addr <= VID_BASE + 26'h7FFF) |-> !cacheable);

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_chk
    logic [SZ_W-1:0]   s;
    logic [ADDR_W-1:0] full_base;
    always_comb begin
      s         = q_sz[g*SZ_W +: SZ_W];
      full_base = {q_base[g*BW +: BW], {BLK_LSB{1'b0}}};
    end
    // R7 / R10: an address inside an enabled block never comes out cacheable
    p_blk_r7: assert property (@(posedge clk) disable iff (!rst_n)
      q_vld && !s[SZ_W-1] &&
      ((q_addr >> (BLK_LSB + s[SZ_W-2:0])) == (full_base >> (BLK_LSB + s[SZ_W-2:0])))
      |-> !cacheable);
  end
endmodule

bind cache_range_dec cache_range_dec_chk #(.NUM_BLK(NUM_BLK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .cache_en   (cache_en),
  .limit_code (limit_code),
  .mem_mb     (mem_mb),
  .video_nc   (video_nc),
  .blk_size   (blk_size),
  .blk_base   (blk_base),
  .cacheable  (cacheable)
);

// File: tb/cache_range_dec_tb.sv
module cache_range_dec_tb;
  logic        clk;
  logic        rst_n;
  logic [25:0] addr;
  logic        cache_en;
  logic [3:0]  limit_code;
  logic [6:0]  mem_mb;
  logic        video_nc;
  logic [5:0]  blk_size;
  logic [19:0] blk_base;
  logic        cacheable;

  int checks;
  int errors;
  bit done;

  cache_range_dec u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .cache_en   (cache_en),
    .limit_code (limit_code),
    .mem_mb     (mem_mb),
    .video_nc   (video_nc),
    .blk_size   (blk_size),
    .blk_base   (blk_base),
    .cacheable  (cacheable)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic expect_bit(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%b expected=%b", req, addr, act, exp);
    end
  endtask

  // Present an address at a falling edge; result is visible after the next rising edge.
  task automatic probe(input logic [25:0] a, input logic exp, input string req);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    expect_bit(cacheable, exp, req);
  endtask

  task automatic defaults();
    cache_en   = 1'b1;
    limit_code = 4'd0;
    mem_mb     = 7'd16;
    video_nc   = 1'b0;
    blk_size   = {3'b100, 3'b100};
    blk_base   = '0;
  endtask

  task automatic t_reset();
    expect_bit(cacheable, 1'b0, "R11 reset");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_disable();
    defaults();
    cache_en = 1'b0;
    probe(26'h0001000, 1'b0, "R1");
    probe(26'h3FFFFFF, 1'b0, "R1");
    cache_en = 1'b1;
    probe(26'h0001000, 1'b1, "R1");
  endtask

  task automatic t_limit();
    defaults();
    probe(26'h3FFFFFF, 1'b1, "R3");
    probe(26'h0000000, 1'b1, "R3");
    limit_code = 4'd1;
    probe(26'h03FFFFF, 1'b1, "R2");
    probe(26'h0400000, 1'b0, "R2");
    limit_code = 4'd15;
    probe(26'h3BFFFFF, 1'b1, "R2");
    probe(26'h3C00000, 1'b0, "R2");
  endtask

  task automatic t_small();
    defaults();
    mem_mb = 7'd1;
    probe(26'h00FFFFF, 1'b1, "R4");
    probe(26'h0100000, 1'b0, "R4");
    mem_mb = 7'd2; limit_code = 4'd3;
    probe(26'h01FFFFF, 1'b1, "R4");
    probe(26'h0200000, 1'b0, "R4");
    mem_mb = 7'd3; limit_code = 4'd1;
    probe(26'h03FFFFF, 1'b1, "R4");
    probe(26'h0400000, 1'b0, "R4");
  endtask

  task automatic t_video();
    defaults();
    video_nc = 1'b1;
    probe(26'h00C0000, 1'b0, "R5");
    probe(26'h00C7FFF, 1'b0, "R5");
    probe(26'h00C8000, 1'b1, "R5");
    probe(26'h00BFFFF, 1'b1, "R5");
    video_nc = 1'b0;
    probe(26'h00C4000, 1'b1, "R6");
  endtask

  task automatic t_sizes();
    defaults();
    blk_size[2:0] = 3'd0; blk_base[9:0] = 10'h012;
    probe(26'h0120000, 1'b0, "R7");
    probe(26'h012FFFF, 1'b0, "R7");
    probe(26'h0130000, 1'b1, "R7");
    probe(26'h011FFFF, 1'b1, "R7");
    blk_size[2:0] = 3'd1; blk_base[9:0] = 10'h012;
    probe(26'h013FFFF, 1'b0, "R7");
    probe(26'h0140000, 1'b1, "R7");
    blk_size[2:0] = 3'd3; blk_base[9:0] = 10'h010;
    probe(26'h017FFFF, 1'b0, "R7");
    probe(26'h0180000, 1'b1, "R7");
  endtask

  task automatic t_reserved();
    defaults();
    blk_base[9:0] = 10'h012;
    blk_size[2:0] = 3'd4;
    probe(26'h0120000, 1'b1, "R8");
    blk_size[2:0] = 3'd7;
    probe(26'h0120000, 1'b1, "R8");
  endtask

  task automatic t_align();
    defaults();
    blk_size[2:0] = 3'd2; blk_base[9:0] = 10'h013;
    probe(26'h0100000, 1'b0, "R9");
    probe(26'h013FFFF, 1'b0, "R9");
    probe(26'h0140000, 1'b1, "R9");
    blk_size[2:0] = 3'd0; blk_base[9:0] = 10'h205;
    probe(26'h2050000, 1'b0, "R9");
    probe(26'h0050000, 1'b1, "R9");
  endtask

  task automatic t_two();
    defaults();
    blk_size[5:3] = 3'd0; blk_base[19:10] = 10'h030;
    probe(26'h0300000, 1'b0, "R10");
    probe(26'h0120000, 1'b1, "R10");
    blk_size[2:0] = 3'd0; blk_base[9:0] = 10'h012;
    probe(26'h0120000, 1'b0, "R10");
    probe(26'h0300000, 1'b0, "R10");
    probe(26'h0200000, 1'b1, "R10");
  endtask

  task automatic t_latency();
    defaults();
    probe(26'h0001000, 1'b1, "R11");
    @(negedge clk);
    cache_en = 1'b0;
    #2;
    expect_bit(cacheable, 1'b1, "R11 hold");
    @(negedge clk);
    expect_bit(cacheable, 1'b0, "R11 update");
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b1;
    addr  = '0;
    defaults();
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_disable();
    t_limit();
    t_small();
    t_video();
    t_sizes();
    t_reserved();
    t_align();
    t_two();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule